// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Controller

This block runs the bus side of a CPU interrupt-acknowledge cycle. When the CPU raises its acknowledge strobe, the controller takes the acknowledged level from address bits 5..2. It uses the live bus bits when the virtual-mode flag is 1. When the flag is 0 it uses a copy of those bits captured earlier on a separate latch enable.

The bit pattern decides between two paths. Off-board sources are expansion cards that supply their own vector. For these the controller asks the memory controller for bypass mode and waits for its acknowledge. It then asks the bus arbiter for the bus and waits for the grant. Only then does it raise the one external acknowledge strobe that belongs to that level. On-board sources get their own level driven back onto the data bus as the vector, together with a wait-select.

All requests, strobes and drivers are released in the same cycle the CPU strobe falls. One recovery cycle follows before a new acknowledge is accepted.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, byp_req_o, arb_req_o, ext_ack_o, vec_oe_o and wsel_o are all 0, and vec_o is 0.
- R2: With virt_i=1 the level is addr_i as sampled at the edge where the cycle starts. With virt_i=0 it is the value held from the last edge at which addr_le_i was 1.
- R3: A level is off-board when its bit 0 (address bit 2) is 0 and bit 1 or bit 2 is 1. Level 10 maps to ext_ack_o[0], level 12 to ext_ack_o[1] and level 14 to ext_ack_o[2]. Every other pattern is on-board.
- R4: For an off-board level, byp_req_o rises in the cycle after the edge that sees iack_i. arb_req_o stays 0 until an edge sees byp_ack_i=1.
- R5: arb_req_o rises in the cycle after byp_ack_i is seen. The matching ext_ack_o bit rises only in the cycle after an edge that sees arb_gnt_i=1, and at most one bit is ever set.
- R6: For an on-board level, in the cycle after the start edge, vec_oe_o=1, wsel_o=1 and vec_o equals the level zero-extended to 8 bits. No bypass or arbiter request is made.
- R7: When iack_i falls, byp_req_o, arb_req_o, ext_ack_o, vec_oe_o and wsel_o drop in that same cycle, without waiting for a clock edge.
- R8: After the strobe ends there is one recovery cycle. An iack_i seen at the first edge after the drop is ignored, and the cycle starts at the next edge.
- R9: If iack_i falls while the controller waits for bypass acknowledge or grant, it returns to idle with no external strobe. This holds even if the grant arrives in that same cycle.
- R10: vec_o is 0 whenever vec_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iack_i | input | 1 | CPU interrupt-acknowledge strobe, held for the whole cycle |
| virt_i | input | 1 | 1: use live address bits; 0: use latched copy |
| addr_i | input | 4 | Address bits 5..2 |
| addr_le_i | input | 1 | Latch enable for the address copy |
| byp_ack_i | input | 1 | Memory controller bypass acknowledge |
| arb_gnt_i | input | 1 | Bus arbiter grant |
| byp_req_o | output | 1 | Bypass-mode request |
| arb_req_o | output | 1 | Bus arbiter request |
| ext_ack_o | output | 3 | External acknowledge strobes for levels 10, 12, 14 |
| vec_o | output | 8 | Vector data for on-board sources |
| vec_oe_o | output | 1 | Data bus driver enable (bus tri-stated when 0) |
| wsel_o | output | 1 | Wait-select for on-board acknowledge |

## Verification
The CPU ending the cycle can fall in the same cycle as a handshake step finishing. Two such collisions are set up. In one, the strobe drops in the cycle the grant arrives. In the other, the strobe drops while the controller is still waiting for the bypass acknowledge. In both cases the requests must vanish at once, and no external strobe may appear at the following edges. The latch enable is pulsed ahead of a virtual-mode-0 cycle whose live address differs, so the bench can tell which copy was used.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned LVL_W     = 4;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned N_EXT     = 3;
  localparam int unsigned EXT_IDX_W = $clog2(N_EXT);

  typedef enum logic [2:0] {
    S_IDLE, S_BYP, S_ARB, S_OFF, S_ONB, S_DONE
  } ack_st_e;
endpackage

// File: rtl/irq_lvl_sel.sv
module irq_lvl_sel
  import irq_ack_pkg::*;
#(
  parameter int unsigned LW = LVL_W,
  parameter int unsigned XW = EXT_IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          virt_i,
  input  logic [LW-1:0] addr_i,
  input  logic          addr_le_i,
  input  logic          cap_i,
  output logic          off_o,
  output logic [LW-1:0] lvl_o,
  output logic [XW-1:0] ext_idx_o
);
  logic [LW-1:0] addr_q, lvl_sel, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        addr_q <= '0;
    else if (addr_le_i) addr_q <= addr_i;

  assign lvl_sel = virt_i ? addr_i : addr_q;
  // off-board: addr bit2 low, bit3 or bit4 high
  assign off_o   = !lvl_sel[0] && (lvl_sel[1] || lvl_sel[2]);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    lvl_q <= '0;
    else if (cap_i) lvl_q <= lvl_sel;

  assign lvl_o     = lvl_q;
  assign ext_idx_o = XW'(lvl_q[2:1] - 2'd1);
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_ack_pkg::*;
#(
  parameter int unsigned NX = N_EXT,
  parameter int unsigned XW = EXT_IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          iack_i,
  input  logic          off_i,
  input  logic [XW-1:0] ext_idx_i,
  input  logic          byp_ack_i,
  input  logic          arb_gnt_i,
  output logic          cap_o,
  output logic          byp_req_o,
  output logic          arb_req_o,
  output logic [NX-1:0] ext_ack_o,
  output logic          drv_o
);
  ack_st_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (iack_i) st_d = off_i ? S_BYP : S_ONB;
      S_BYP:  if (!iack_i) st_d = S_DONE; else if (byp_ack_i) st_d = S_ARB;
      S_ARB:  if (!iack_i) st_d = S_DONE; else if (arb_gnt_i) st_d = S_OFF;
      S_OFF,
      S_ONB:  if (!iack_i) st_d = S_DONE;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign cap_o = (st_q == S_IDLE) && iack_i;

  // outputs gated by the live strobe so they drop in the cycle it falls
  logic off_act;
  assign byp_req_o = iack_i && (st_q == S_BYP || st_q == S_ARB || st_q == S_OFF);
  assign arb_req_o = iack_i && (st_q == S_ARB || st_q == S_OFF);
  assign off_act   = iack_i && (st_q == S_OFF);
  assign drv_o     = iack_i && (st_q == S_ONB);

  for (genvar g = 0; g < NX; g++) begin : g_ext
    assign ext_ack_o[g] = off_act && (ext_idx_i == XW'(g));
  end

  a_r4_arb_after_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_req_o) |-> $past(byp_req_o && byp_ack_i));
  a_r5_grant_before_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|ext_ack_o) |-> $past(arb_req_o && arb_gnt_i));
  a_r5_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ext_ack_o));
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_i |-> !byp_req_o && !arb_req_o && ext_ack_o == '0 && !drv_o);
  a_r8_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_DONE |=> st_q == S_IDLE);
endmodule

// File: rtl/irq_vec_drv.sv
module irq_vec_drv #(
  parameter int unsigned LW = 4,
  parameter int unsigned VW = 8
) (
  input  logic          drv_i,
  input  logic [LW-1:0] lvl_i,
  output logic [VW-1:0] vec_o,
  output logic          vec_oe_o,
  output logic          wsel_o
);
  assign vec_o    = drv_i ? VW'(lvl_i) : '0;
  assign vec_oe_o = drv_i;
  assign wsel_o   = drv_i;
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int unsigned LW = LVL_W,
  parameter int unsigned VW = VEC_W,
  parameter int unsigned NX = N_EXT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          iack_i,
  input  logic          virt_i,
  input  logic [LW-1:0] addr_i,
  input  logic          addr_le_i,
  input  logic          byp_ack_i,
  input  logic          arb_gnt_i,
  output logic          byp_req_o,
  output logic          arb_req_o,
  output logic [NX-1:0] ext_ack_o,
  output logic [VW-1:0] vec_o,
  output logic          vec_oe_o,
  output logic          wsel_o
);
  localparam int unsigned XW = (NX > 1) ? $clog2(NX) : 1;

  logic          cap, off, drv;
  logic [LW-1:0] lvl;
  logic [XW-1:0] ext_idx;

  irq_lvl_sel #(.LW(LW), .XW(XW)) u_sel (
    .clk_i, .rst_ni, .virt_i, .addr_i, .addr_le_i,
    .cap_i(cap), .off_o(off), .lvl_o(lvl), .ext_idx_o(ext_idx)
  );

  irq_ack_fsm #(.NX(NX), .XW(XW)) u_fsm (
    .clk_i, .rst_ni, .iack_i, .off_i(off), .ext_idx_i(ext_idx),
    .byp_ack_i, .arb_gnt_i, .cap_o(cap), .byp_req_o, .arb_req_o,
    .ext_ack_o, .drv_o(drv)
  );

  irq_vec_drv #(.LW(LW), .VW(VW)) u_drv (
    .drv_i(drv), .lvl_i(lvl), .vec_o, .vec_oe_o, .wsel_o
  );

  a_r6_onboard_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wsel_o |-> !byp_req_o && !arb_req_o && ext_ack_o == '0);
  a_r10_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_oe_o |-> vec_o == '0);
endmodule

// File: tb/irq_ack_ctrl_test.sv
module irq_ack_ctrl_test;
  logic       clk = 0, rst_n = 0;
  logic       iack = 0, virt = 1, addr_le = 0, byp_ack = 0, arb_gnt = 0;
  logic [3:0] addr = 0;
  logic       byp_req, arb_req, vec_oe, wsel;
  logic [2:0] ext_ack;
  logic [7:0] vec;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_ack_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .iack_i(iack), .virt_i(virt), .addr_i(addr),
    .addr_le_i(addr_le), .byp_ack_i(byp_ack), .arb_gnt_i(arb_gnt),
    .byp_req_o(byp_req), .arb_req_o(arb_req), .ext_ack_o(ext_ack),
    .vec_o(vec), .vec_oe_o(vec_oe), .wsel_o(wsel)
  );

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_cycle(string rq);
    @(negedge clk); iack = 0; byp_ack = 0; arb_gnt = 0; #1;
    chk(rq, "byp_req after drop", byp_req, 0);
    chk(rq, "arb_req after drop", arb_req, 0);
    chk(rq, "ext_ack after drop", ext_ack, 0);
    chk(rq, "vec_oe after drop", vec_oe, 0);
    chk(rq, "wsel after drop", wsel, 0);
    tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1", "byp_req", byp_req, 0); chk("R1", "arb_req", arb_req, 0);
    chk("R1", "ext_ack", ext_ack, 0); chk("R1", "vec_oe", vec_oe, 0);
    chk("R1", "wsel", wsel, 0);       chk("R1", "vec", vec, 0);
  endtask

  task automatic t_onboard(logic [3:0] lv);
    @(negedge clk); virt = 1; addr = lv; iack = 1;
    tick();
    chk("R6", "vec_oe", vec_oe, 1); chk("R6", "wsel", wsel, 1);
    chk("R6", "vec", vec, int'(lv)); chk("R6", "byp_req", byp_req, 0);
    chk("R3", "ext_ack onboard", ext_ack, 0);
    @(negedge clk); addr = ~lv; tick();
    chk("R6", "vec held", vec, int'(lv));
    finish_cycle("R7");
    chk("R10", "vec idle", vec, 0);
  endtask

  task automatic run_offboard(string rq, int exp_ext);
    chk("R4", "byp_req", byp_req, 1); chk("R4", "arb_req early", arb_req, 0);
    chk("R3", "wsel offboard", wsel, 0);
    repeat (3) tick();
    chk("R4", "arb_req waits", arb_req, 0);
    @(negedge clk); byp_ack = 1; tick();
    chk("R5", "arb_req", arb_req, 1); chk("R5", "ext before grant", ext_ack, 0);
    @(negedge clk); byp_ack = 0; tick(); tick();
    chk("R5", "ext waits grant", ext_ack, 0);
    @(negedge clk); arb_gnt = 1; tick();
    chk(rq, "ext_ack", ext_ack, exp_ext);
    chk("R5", "byp_req held", byp_req, 1);
    finish_cycle("R7");
  endtask

  task automatic t_offboard(logic [3:0] lv, int exp_ext);
    @(negedge clk); virt = 1; addr = lv; iack = 1;
    tick();
    run_offboard("R3", exp_ext);
  endtask

  task automatic t_latched();
    @(negedge clk); addr = 4'hA; addr_le = 1;
    @(negedge clk); addr_le = 0; addr = 4'hB; virt = 0; iack = 1;
    tick();
    run_offboard("R2", 1);
    @(negedge clk); addr = 4'hB; addr_le = 1;
    @(negedge clk); addr_le = 0; addr = 4'hE; virt = 0; iack = 1;
    tick();
    chk("R2", "latched onboard vec", vec, 11);
    chk("R2", "latched byp_req", byp_req, 0);
    finish_cycle("R7");
    virt = 1;
  endtask

  task automatic t_abort_grant();
    @(negedge clk); addr = 4'hE; iack = 1;
    tick();
    @(negedge clk); byp_ack = 1; tick();
    @(negedge clk); byp_ack = 0; iack = 0; arb_gnt = 1; #1;
    chk("R9", "arb_req dropped", arb_req, 0);
    tick(); chk("R9", "ext after late grant", ext_ack, 0);
    tick(); chk("R9", "ext idle", ext_ack, 0);
    @(negedge clk); arb_gnt = 0; tick();
    chk("R9", "byp_req idle", byp_req, 0);
  endtask

  task automatic t_abort_bypass();
    @(negedge clk); addr = 4'hC; iack = 1;
    tick();
    @(negedge clk); iack = 0; byp_ack = 1; #1;
    chk("R9", "byp_req dropped", byp_req, 0);
    tick(); tick();
    @(negedge clk); byp_ack = 0; tick();
    chk("R9", "arb_req never", arb_req, 0);
    chk("R9", "ext never", ext_ack, 0);
  endtask

  task automatic t_rearm();
    @(negedge clk); addr = 4'h9; iack = 1;
    tick();
    @(negedge clk); iack = 0; tick();
    @(negedge clk); iack = 1; tick();
    chk("R8", "ignored in recovery", vec_oe, 0);
    tick();
    chk("R8", "accepted after recovery", vec_oe, 1);
    chk("R8", "vec", vec, 9);
    finish_cycle("R7");
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk); rst_n = 1;
    tick();
    t_reset();
    t_onboard(4'h8); t_onboard(4'hF); t_onboard(4'hD); t_onboard(4'h0);
    t_offboard(4'hA, 1); t_offboard(4'hC, 2); t_offboard(4'hE, 4);
    t_latched();
    t_abort_grant();
    t_abort_bypass();
    t_rearm();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule